// File: doc/BRIEF.md
# Operand Address Generator

This block turns one operand description of an 8-bit microcontroller instruction into the location the operand lives in. It supports four modes: banked working register, direct byte address, register indirect, and immediate constant. For each operand it produces an address, a tag naming the space the address belongs to, and, for constants, the constant value itself. The memories and the arithmetic unit are outside the block. The decode stage presents one request per cycle with `in_valid`. The result appears one clock later, and the memory stage then acts on it.

A working register sits in one of four banks of eight bytes in internal RAM, so its location depends on the two bank select bits. A direct byte below 80h names internal RAM; the upper half of that byte range names the special function registers. Indirect access through a register is allowed only with register 0 or 1, each holding an 8-bit pointer. A request can instead name the 16-bit data pointer, which reaches external memory. An indirect request that names any other register is rejected with an error pulse.

Top module: `opnd_addr_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` and `out_err` are 0, and `out_addr`, `out_space` and `out_imm` are 0.
- R2: A request accepted with `in_valid`=1 at a clock edge gives its result in the registered outputs right after that edge. `out_valid` is high for exactly that one cycle per request.
- R3: Mode 0 (banked register) gives `out_addr` = `bank_sel`×8 + `reg_num`, zero-extended, with `out_space` = 0 (internal RAM).
- R4: Mode 1 (direct) with `dir_addr` below 80h gives `out_addr` = `dir_addr` and `out_space` = 0 (internal RAM).
- R5: Mode 1 (direct) with `dir_addr` at 80h or above gives `out_addr` = `dir_addr` and `out_space` = 1 (special function register).
- R6: Mode 2 (indirect) with `use_dptr`=0 and `reg_num` 0 or 1 gives `out_addr` = `ptr_r0` or `ptr_r1`, zero-extended, with `out_space` = 0.
- R7: Mode 2 with `use_dptr`=1 gives `out_addr` = `dptr` and `out_space` = 2 (external memory), whatever `reg_num` holds.
- R8: Mode 2 with `use_dptr`=0 and `reg_num` of 2 or more gives `out_err`=1 and `out_valid`=0 for one cycle. `out_addr`, `out_space` and `out_imm` keep their previous values.
- R9: Mode 3 (immediate) with `imm_wide`=0 gives `out_imm` = `imm_lo` zero-extended. `imm_hi` is ignored. `out_space` = 3 and `out_addr` = 0.
- R10: Mode 3 with `imm_wide`=1 gives `out_imm` = {`imm_hi`,`imm_lo`}, with `out_space` = 3.
- R11: A cycle with `in_valid`=0 leaves `out_valid` and `out_err` at 0 after the next edge. `out_addr`, `out_space` and `out_imm` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 2 | 0 register, 1 direct, 2 indirect, 3 immediate |
| reg_num | input | 3 | Register number |
| bank_sel | input | 2 | Active register bank |
| dir_addr | input | 8 | Direct address byte |
| use_dptr | input | 1 | Indirect through the 16-bit data pointer |
| ptr_r0 | input | 8 | Contents of register 0 |
| ptr_r1 | input | 8 | Contents of register 1 |
| dptr | input | 16 | Data pointer contents |
| imm_lo | input | 8 | Constant low byte |
| imm_hi | input | 8 | Constant high byte |
| imm_wide | input | 1 | Constant is 16 bits |
| out_valid | output | 1 | Result valid |
| out_err | output | 1 | Illegal indirect register |
| out_addr | output | 16 | Effective address |
| out_space | output | 2 | 0 RAM, 1 SFR, 2 external, 3 immediate |
| out_imm | output | 16 | Constant value |

## Verification
Every result, error pulse and hold is due in the cycle that directly follows the edge that accepted the request, because exactly one register stage lies between the inputs and the outputs. The bench drives each request on a falling edge and samples one nanosecond after the next rising edge. It removes `in_valid` on the following falling edge. It then samples again after one more rising edge to confirm that `out_valid` has dropped and the data has held. The error case and the ignored high constant byte are checked at the ports in that same sampled cycle.

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen #(
  parameter int DW     = 8,
  parameter int AW     = 16,
  parameter int BANK_W = 2,
  parameter int REG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        mode,
  input  logic [REG_W-1:0]  reg_num,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [DW-1:0]     dir_addr,
  input  logic              use_dptr,
  input  logic [DW-1:0]     ptr_r0,
  input  logic [DW-1:0]     ptr_r1,
  input  logic [AW-1:0]     dptr,
  input  logic [DW-1:0]     imm_lo,
  input  logic [DW-1:0]     imm_hi,
  input  logic              imm_wide,
  output logic              out_valid,
  output logic              out_err,
  output logic [AW-1:0]     out_addr,
  output logic [1:0]        out_space,
  output logic [2*DW-1:0]   out_imm
);
  localparam logic [1:0] M_REG = 2'd0, M_DIR = 2'd1, M_IND = 2'd2, M_IMM = 2'd3;
  localparam logic [1:0] SP_RAM = 2'd0, SP_SFR = 2'd1, SP_EXT = 2'd2, SP_IMM = 2'd3;
  localparam int RPAD = AW - BANK_W - REG_W;
  localparam int BPAD = AW - DW;

  logic            ptr_reg_ok;
  logic            req_ok;
  logic [AW-1:0]   nxt_addr;
  logic [1:0]      nxt_space;
  logic [2*DW-1:0] nxt_imm;

  assign ptr_reg_ok = (reg_num == REG_W'(0)) || (reg_num == REG_W'(1));
  assign req_ok     = (mode != M_IND) || use_dptr || ptr_reg_ok;

  always_comb begin
    nxt_addr  = '0;
    nxt_space = SP_RAM;
    nxt_imm   = '0;
    case (mode)
      M_REG: nxt_addr = {{RPAD{1'b0}}, bank_sel, reg_num};
      M_DIR: begin
        nxt_addr  = {{BPAD{1'b0}}, dir_addr};
        nxt_space = dir_addr[DW-1] ? SP_SFR : SP_RAM;
      end
      M_IND: begin
        if (use_dptr) begin
          nxt_addr  = dptr;
          nxt_space = SP_EXT;
        end else begin
          nxt_addr = {{BPAD{1'b0}}, (reg_num[0] ? ptr_r1 : ptr_r0)};
        end
      end
      default: begin
        nxt_space = SP_IMM;
        nxt_imm   = imm_wide ? {imm_hi, imm_lo} : {{DW{1'b0}}, imm_lo};
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_addr  <= '0;
      out_space <= SP_RAM;
      out_imm   <= '0;
    end else begin
      out_valid <= in_valid && req_ok;
      out_err   <= in_valid && !req_ok;
      if (in_valid && req_ok) begin
        out_addr  <= nxt_addr;
        out_space <= nxt_space;
        out_imm   <= nxt_imm;
      end
    end
  end
endmodule

module opnd_addr_gen_chk #(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [1:0]    mode,
  input logic [7:0]    dir_addr,
  input logic          use_dptr,
  input logic          out_valid,
  input logic          out_err,
  input logic [AW-1:0] out_addr,
  input logic [1:0]    out_space
);
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_err)); // R8
  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !out_err); // R2
  AST_REG_IN_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd0) |=> (out_valid && out_space == 2'd0 && out_addr[AW-1:5] == '0)); // R3
  AST_DIR_HIGH_SFR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd1 && dir_addr[7]) |=> (out_space == 2'd1)); // R5
  AST_DPTR_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd2 && use_dptr) |=> (out_valid && out_space == 2'd2)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_addr) && $stable(out_space))); // R11
  AST_IMM_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd3) |=> (out_space == 2'd3 && out_addr == '0)); // R9
endmodule

bind opnd_addr_gen opnd_addr_gen_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
  .dir_addr(dir_addr), .use_dptr(use_dptr), .out_valid(out_valid),
  .out_err(out_err), .out_addr(out_addr), .out_space(out_space)
);

// File: tb/tb_opnd_addr_gen.sv
module tb_opnd_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  mode = '0;
  logic [2:0]  reg_num = '0;
  logic [1:0]  bank_sel = '0;
  logic [7:0]  dir_addr = '0;
  logic        use_dptr = 1'b0;
  logic [7:0]  ptr_r0 = '0;
  logic [7:0]  ptr_r1 = '0;
  logic [15:0] dptr = '0;
  logic [7:0]  imm_lo = '0;
  logic [7:0]  imm_hi = '0;
  logic        imm_wide = 1'b0;
  logic        out_valid, out_err;
  logic [15:0] out_addr, out_imm;
  logic [1:0]  out_space;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  opnd_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .reg_num(reg_num),
    .bank_sel(bank_sel), .dir_addr(dir_addr), .use_dptr(use_dptr), .ptr_r0(ptr_r0),
    .ptr_r1(ptr_r1), .dptr(dptr), .imm_lo(imm_lo), .imm_hi(imm_hi), .imm_wide(imm_wide),
    .out_valid(out_valid), .out_err(out_err), .out_addr(out_addr),
    .out_space(out_space), .out_imm(out_imm)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] m, input logic [2:0] rn, input logic [1:0] bk,
                       input logic [7:0] da, input logic ud);
    @(negedge clk);
    mode = m; reg_num = rn; bank_sel = bk; dir_addr = da; use_dptr = ud;
    in_valid = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic idle_after(input string tag);
    logic [15:0] a, im;
    logic [1:0]  s;
    a = out_addr; s = out_space; im = out_imm;
    @(negedge clk);
    in_valid = 1'b0;
    mode = 2'd3; imm_lo = 8'h5A; imm_wide = 1'b1;
    @(posedge clk); #1;
    chk({tag, " R2 valid one cycle"}, out_valid, 0);
    chk({tag, " R11 addr hold"}, out_addr, a);
    chk({tag, " R11 space hold"}, out_space, s);
    chk({tag, " R11 imm hold"}, out_imm, im);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 valid in reset", out_valid, 0);
    chk("R1 err in reset", out_err, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 valid after reset", out_valid, 0);
    chk("R1 addr after reset", out_addr, 0);
    chk("R1 space after reset", out_space, 0);
    chk("R1 imm after reset", out_imm, 0);
  endtask

  task automatic t_regs();
    for (int b = 0; b < 4; b++) begin
      issue(2'd0, 3'(7 - 2*b), 2'(b), 8'hEE, 1'b0);
      chk("R2 valid reg", out_valid, 1);
      chk("R3 reg addr", out_addr, 32'(b*8 + 7 - 2*b));
      chk("R3 reg space", out_space, 0);
    end
    idle_after("reg");
  endtask

  task automatic t_direct();
    logic [7:0] v[4] = '{8'h00, 8'h7F, 8'h80, 8'hF8};
    for (int i = 0; i < 4; i++) begin
      issue(2'd1, 3'd5, 2'd2, v[i], 1'b1);
      chk(v[i][7] ? "R5 dir addr" : "R4 dir addr", out_addr, {24'h0, v[i]});
      chk(v[i][7] ? "R5 dir space" : "R4 dir space", out_space, v[i][7] ? 1 : 0);
    end
    idle_after("dir");
  endtask

  task automatic t_indirect();
    ptr_r0 = 8'h60; ptr_r1 = 8'hC3; dptr = 16'h1234;
    issue(2'd2, 3'd0, 2'd3, 8'h11, 1'b0);
    chk("R6 r0 addr", out_addr, 16'h0060);
    chk("R6 r0 space", out_space, 0);
    issue(2'd2, 3'd1, 2'd1, 8'h11, 1'b0);
    chk("R6 r1 addr", out_addr, 16'h00C3);
    chk("R6 r1 valid", out_valid, 1);
    issue(2'd2, 3'd5, 2'd0, 8'h11, 1'b1);
    chk("R7 dptr addr", out_addr, 16'h1234);
    chk("R7 dptr space", out_space, 2);
    for (int r = 2; r < 8; r += 5) begin
      issue(2'd2, 3'(r), 2'd0, 8'h11, 1'b0);
      chk("R8 err set", out_err, 1);
      chk("R8 valid low", out_valid, 0);
      chk("R8 addr held", out_addr, 16'h1234);
      chk("R8 space held", out_space, 2);
    end
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); #1;
    chk("R8 err one cycle", out_err, 0);
  endtask

  task automatic t_imm();
    imm_lo = 8'h30; imm_hi = 8'hAB; imm_wide = 1'b0;
    issue(2'd3, 3'd1, 2'd1, 8'h90, 1'b1);
    chk("R9 imm8 value", out_imm, 16'h0030);
    chk("R9 imm8 space", out_space, 3);
    chk("R9 imm8 addr", out_addr, 0);
    @(negedge clk); imm_lo = 8'h00; imm_hi = 8'hFE; imm_wide = 1'b1;
    @(posedge clk); #1;
    chk("R10 imm16 value", out_imm, 16'hFE00);
    chk("R10 imm16 space", out_space, 3);
    idle_after("imm");
  endtask

  initial begin
    t_reset();
    t_regs();
    t_direct();
    t_indirect();
    t_imm();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 50000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule